// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a byte-wide memory window in which the top eight addresses are a running calendar clock and every lower address is plain storage. The clock keeps seconds, minutes, hours (24-hour), day of week, day of month, month, two-digit year and century, each as one packed-BCD byte. It advances on a one-cycle `tick` pulse that is expected once per second. Month lengths and leap years are handled during rollover, including the century rule.

The host never touches the running counters directly. Reads come from a holding bank that is refreshed in one step from the counters, so a read never sees a half-updated time. A write goes into the holding bank and marks that field pending. At the next tick the pending fields are loaded into the counters. The count keeps running through any host traffic and through power loss.

A `pwr_good` input gates every access. While it is low, and for `REC_CYC` clock cycles after it returns, reads return zero and writes are dropped. The address width is a parameter. `ADDR_W = 13` gives the full 8192-byte map; the default is smaller so that elaboration stays light.

Top module: `bcd_rtc_mem`

## Requirements
- R1: An accepted write to any address below the top eight stores the byte. An accepted read of that address returns the byte on `rdata` one clock after the read cycle.
- R2: The top eight addresses (offsets 0..7 from `2**ADDR_W-8`) are, in order: century, seconds, minutes, hours, day of week, date, month, year. Reads return the holding bank. A field written by the host reads back as written until the next tick. After reset the time is century 20, year 00, month 01, date 01, day 1, 00:00:00.
- R3: The counters change only on a cycle with `tick` high. Seconds and minutes go from 59 to 00 and carry into the next field.
- R4: Hours go from 23 to 00 and carry into both day of week and date. Day of week goes from 7 to 1.
- R5: Date rolls to 01 and carries into month after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. Month goes from 12 to 01 and carries into year.
- R6: February ends at 29 when the year is a non-zero multiple of 4, or when the year is 00 and the century is a multiple of 4. Otherwise it ends at 28.
- R7: Year goes from 99 to 00 and increments the century. Century goes from 99 to 00.
- R8: A host-written field is copied into its counter at the next tick. That field does not increment on that tick, and it passes no carry upward. The other fields advance normally.
- R9: Timekeeping counts every tick, including ticks that arrive between host accesses and ticks that arrive while access is locked out.
- R10: While `pwr_good` is low, writes to RAM and to clock registers are ignored, and reads return 00.
- R11: After `pwr_good` returns high, access stays blocked for `REC_CYC` clock cycles.
- R12: A host value that is not valid BCD is stored and loaded as given, with no correction.
- R13: Any cycle that does not perform an accepted read leaves `rdata` at 00 on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supply-in-tolerance indication; low blocks access |
| tick | input | 1 | One-cycle pulse that advances the time by one second |
| cs | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered |

## Verification
Rollover is driven from chosen start times:
- end of a 31-day month at year end;
- end of a 30-day month;
- end of February in a plain year, in a leap year, in a leap century year and in a non-leap century year;
- year 99 with century 99.

Each of these separates the month-length and leap decisions from the generic BCD carry.

Host writes placed just before a tick, including over a seconds wrap, show whether the written field's increment and carry are suppressed while the other fields still advance. Ticks mixed with RAM reads and with a power-fail window show that no second is lost. Accesses attempted during the window and shortly after recovery are compared with accesses after the delay, which confirms that the lockout covers both the outage and the recovery count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef logic [7:0]      tfield_t;
    typedef tfield_t [7:0]   tbank_t;

    // field offsets inside the clock window
    localparam int F_CEN  = 0;
    localparam int F_SEC  = 1;
    localparam int F_MIN  = 2;
    localparam int F_HOUR = 3;
    localparam int F_DAY  = 4;
    localparam int F_DATE = 5;
    localparam int F_MON  = 6;
    localparam int F_YEAR = 7;

    // reset time: 2000-01-01, weekday 1, 00:00:00 (index 7 first)
    localparam tbank_t RST_TIME = {8'h00, 8'h01, 8'h01, 8'h01,
                                   8'h00, 8'h00, 8'h00, 8'h20};

    function automatic tfield_t bcd_inc(input tfield_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic logic [6:0] bcd_to_bin(input tfield_t v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction
endpackage

// File: rtl/rtc_lockout.sv
module rtc_lockout #(
    parameter int REC_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic access_ok
);
    localparam int CW = $clog2(REC_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!pwr_good)          cnt_d = CW'(REC_CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CW'(REC_CYC);
        else        cnt_q <= cnt_d;
    end

    assign access_ok = pwr_good && (cnt_q == '0);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  tbank_t     cur,
    input  tbank_t     load_val,
    input  logic [7:0] load_mask,
    input  logic       tick,
    output tbank_t     nxt
);
    logic       leap;
    tfield_t    last_date;
    logic       c_sec, c_min, c_hour, c_date, c_mon, c_year;
    logic [6:0] yb, cb;

    always_comb begin
        yb   = bcd_to_bin(cur[F_YEAR]);
        cb   = bcd_to_bin(cur[F_CEN]);
        leap = (yb == 7'd0) ? (cb[1:0] == 2'd0) : (yb[1:0] == 2'd0);
        case (cur[F_MON])
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

    always_comb begin
        nxt    = cur;
        c_sec  = 1'b0;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_date = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        if (tick) begin
            // seconds
            if (load_mask[F_SEC])            nxt[F_SEC] = load_val[F_SEC];
            else if (cur[F_SEC] == 8'h59)  begin nxt[F_SEC] = 8'h00; c_sec = 1'b1; end
            else                             nxt[F_SEC] = bcd_inc(cur[F_SEC]);
            // minutes
            if (load_mask[F_MIN])            nxt[F_MIN] = load_val[F_MIN];
            else if (c_sec) begin
                if (cur[F_MIN] == 8'h59) begin nxt[F_MIN] = 8'h00; c_min = 1'b1; end
                else                         nxt[F_MIN] = bcd_inc(cur[F_MIN]);
            end
            // hours
            if (load_mask[F_HOUR])           nxt[F_HOUR] = load_val[F_HOUR];
            else if (c_min) begin
                if (cur[F_HOUR] == 8'h23) begin nxt[F_HOUR] = 8'h00; c_hour = 1'b1; end
                else                         nxt[F_HOUR] = bcd_inc(cur[F_HOUR]);
            end
            // day of week
            if (load_mask[F_DAY])            nxt[F_DAY] = load_val[F_DAY];
            else if (c_hour)
                nxt[F_DAY] = (cur[F_DAY] == 8'h07) ? 8'h01 : bcd_inc(cur[F_DAY]);
            // date
            if (load_mask[F_DATE])           nxt[F_DATE] = load_val[F_DATE];
            else if (c_hour) begin
                if (cur[F_DATE] == last_date) begin nxt[F_DATE] = 8'h01; c_date = 1'b1; end
                else                         nxt[F_DATE] = bcd_inc(cur[F_DATE]);
            end
            // month
            if (load_mask[F_MON])            nxt[F_MON] = load_val[F_MON];
            else if (c_date) begin
                if (cur[F_MON] == 8'h12) begin nxt[F_MON] = 8'h01; c_mon = 1'b1; end
                else                         nxt[F_MON] = bcd_inc(cur[F_MON]);
            end
            // year
            if (load_mask[F_YEAR])           nxt[F_YEAR] = load_val[F_YEAR];
            else if (c_mon) begin
                if (cur[F_YEAR] == 8'h99) begin nxt[F_YEAR] = 8'h00; c_year = 1'b1; end
                else                         nxt[F_YEAR] = bcd_inc(cur[F_YEAR]);
            end
            // century
            if (load_mask[F_CEN])            nxt[F_CEN] = load_val[F_CEN];
            else if (c_year)
                nxt[F_CEN] = (cur[F_CEN] == 8'h99) ? 8'h00 : bcd_inc(cur[F_CEN]);
        end
    end
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/bcd_rtc_mem.sv
module bcd_rtc_mem
    import rtc_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int REC_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              tick,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    typedef struct packed {
        tbank_t     cnt;
        tbank_t     hold;
        logic [7:0] pend;
        logic [7:0] rdata;
    } state_t;

    state_t     state_d, state_q;
    logic       access_ok;
    logic       acc, is_time, wr_ram;
    logic [2:0] off;
    logic [7:0] wr_mask;
    logic [7:0] ram_rd;
    tbank_t     cnt_next;
    tbank_t     cnt_q, hold_q;
    logic [7:0] pend_q;

    rtc_lockout #(.REC_CYC(REC_CYC)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .access_ok (access_ok)
    );

    rtc_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (wr_ram),
        .addr  (addr),
        .wdata (wdata),
        .rdata (ram_rd)
    );

    rtc_calendar u_cal (
        .cur       (state_q.cnt),
        .load_val  (state_q.hold),
        .load_mask (state_q.pend),
        .tick      (tick),
        .nxt       (cnt_next)
    );

    assign acc     = cs && access_ok;
    assign is_time = &addr[ADDR_W-1:3];
    assign off     = addr[2:0];
    assign wr_ram  = acc && we && !is_time;

    always_comb begin
        wr_mask = (acc && we && is_time) ? (8'b1 << off) : 8'b0;

        state_d      = state_q;
        state_d.cnt  = cnt_next;
        state_d.pend = (tick ? 8'b0 : state_q.pend) | wr_mask;
        for (int i = 0; i < 8; i++) begin
            if (wr_mask[i])            state_d.hold[i] = wdata;
            else if (state_d.pend[i])  state_d.hold[i] = state_q.hold[i];
            else                       state_d.hold[i] = cnt_next[i];
        end
        if (acc && !we) state_d.rdata = is_time ? state_q.hold[off] : ram_rd;
        else            state_d.rdata = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.cnt   <= RST_TIME;
            state_q.hold  <= RST_TIME;
            state_q.pend  <= 8'b0;
            state_q.rdata <= 8'h00;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata  = state_q.rdata;
    assign cnt_q  = state_q.cnt;
    assign hold_q = state_q.hold;
    assign pend_q = state_q.pend;
endmodule

// File: rtl/rtc_mem_chk.sv
module rtc_mem_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good,
    input logic       tick,
    input logic       cs,
    input logic [7:0] rdata,
    input logic       access_ok,
    input tbank_t     cnt,
    input tbank_t     hold,
    input logic [7:0] pend
);
    AST_STILL_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R3

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !pend[F_SEC] && cnt[F_SEC] == 8'h59 |=> cnt[F_SEC] == 8'h00); // R3

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !pend[F_SEC] && cnt[F_SEC] == 8'h23 |=> cnt[F_SEC] == 8'h24); // R9

    AST_PENDING_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tick && pend[F_MIN] |=> cnt[F_MIN] == $past(hold[F_MIN])); // R8

    AST_LOW_POWER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> !access_ok); // R10

    AST_RECOVERY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_good) |-> !access_ok); // R11

    AST_BLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cs && !access_ok |=> rdata == 8'h00); // R13
endmodule

bind bcd_rtc_mem rtc_mem_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .tick      (tick),
    .cs        (cs),
    .rdata     (rdata),
    .access_ok (access_ok),
    .cnt       (cnt_q),
    .hold      (hold_q),
    .pend      (pend_q)
);

// File: tb/bcd_rtc_mem_tb.sv
`timescale 1ns/1ps
module bcd_rtc_mem_tb;
    localparam int AW  = 11;
    localparam int REC = 16;
    localparam logic [AW-1:0] TB = AW'((1 << AW) - 8);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_good = 1'b1;
    logic          tick = 1'b0;
    logic          cs = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    int            total = 0;
    int            bad = 0;

    always #2.5 clk = ~clk;

    bcd_rtc_mem #(.ADDR_W(AW), .REC_CYC(REC)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .tick(tick),
        .cs(cs), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
        @(negedge clk); d = rdata; cs = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bank order: century, sec, min, hour, day, date, month, year
    task automatic set_time(input logic [7:0] c, y, mo, dt, dy, h, mi, s);
        wr(TB + 0, c);  wr(TB + 1, s);  wr(TB + 2, mi); wr(TB + 3, h);
        wr(TB + 4, dy); wr(TB + 5, dt); wr(TB + 6, mo); wr(TB + 7, y);
        pulse_tick();
    endtask

    task automatic chk_time(input string tag, input logic [7:0] c, y, mo, dt, dy, h, mi, s);
        logic [7:0] v;
        rd(TB + 0, v); check({tag, " century"}, v, c);
        rd(TB + 1, v); check({tag, " sec"}, v, s);
        rd(TB + 2, v); check({tag, " min"}, v, mi);
        rd(TB + 3, v); check({tag, " hour"}, v, h);
        rd(TB + 4, v); check({tag, " day"}, v, dy);
        rd(TB + 5, v); check({tag, " date"}, v, dt);
        rd(TB + 6, v); check({tag, " month"}, v, mo);
        rd(TB + 7, v); check({tag, " year"}, v, y);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R13 rdata after reset", rdata, 8'h00);
        chk_time("R2 reset", 8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
        pulse_tick();
        rd(TB + 1, v); check("R3 first tick sec", v, 8'h01);
    endtask

    task automatic t_ram();
        logic [7:0] v;
        wr(0, 8'h11); wr(AW'(12'h123), 8'h5A); wr(TB - 1, 8'hC3);
        rd(0, v);           check("R1 ram addr 0", v, 8'h11);
        rd(AW'(12'h123), v); check("R1 ram mid", v, 8'h5A);
        rd(TB - 1, v);      check("R1 ram below clock", v, 8'hC3);
        wait_cyc(1);        check("R13 idle rdata", rdata, 8'h00);
    endtask

    task automatic t_rollover();
        set_time(8'h20, 8'h23, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        chk_time("R4 R5 R7 year end", 8'h20, 8'h24, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
        set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        chk_time("R7 century up", 8'h20, 8'h00, 8'h01, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00);
        set_time(8'h99, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        chk_time("R7 century wrap", 8'h00, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
        set_time(8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        chk_time("R5 30-day month", 8'h20, 8'h24, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00);
        set_time(8'h20, 8'h24, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        chk_time("R5 31-day month", 8'h20, 8'h24, 8'h01, 8'h31, 8'h03, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_leap();
        logic [7:0] v;
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        rd(TB + 5, v); check("R6 2024 feb date", v, 8'h29);
        rd(TB + 6, v); check("R6 2024 feb month", v, 8'h02);
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        rd(TB + 5, v); check("R6 2023 feb date", v, 8'h01);
        rd(TB + 6, v); check("R6 2023 feb month", v, 8'h03);
        set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        rd(TB + 5, v); check("R6 2000 feb date", v, 8'h29);
        set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        rd(TB + 5, v); check("R6 2100 feb date", v, 8'h01);
        rd(TB + 6, v); check("R6 2100 feb month", v, 8'h03);
    endtask

    task automatic t_write_load();
        logic [7:0] v;
        set_time(8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h00, 8'h00, 8'h10);
        wr(TB + 2, 8'h45);
        rd(TB + 2, v); check("R2 holding readback", v, 8'h45);
        pulse_tick();
        rd(TB + 1, v); check("R8 other field advances", v, 8'h11);
        rd(TB + 2, v); check("R8 written field loaded", v, 8'h45);
        set_time(8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h00, 8'h00, 8'h59);
        wr(TB + 2, 8'h30);
        pulse_tick();
        rd(TB + 1, v); check("R8 sec wraps", v, 8'h00);
        rd(TB + 2, v); check("R8 carry into written min dropped", v, 8'h30);
        rd(TB + 3, v); check("R8 hour untouched", v, 8'h00);
        wr(TB + 1, 8'h7A);
        rd(TB + 1, v); check("R12 invalid bcd held", v, 8'h7A);
        pulse_tick();
        rd(TB + 1, v); check("R12 invalid bcd loaded", v, 8'h7A);
    endtask

    task automatic t_power();
        logic [7:0] v;
        set_time(8'h20, 8'h24, 8'h03, 8'h15, 8'h05, 8'h10, 8'h20, 8'h05);
        wr(AW'(12'h010), 8'hA5);
        for (int i = 0; i < 3; i++) begin
            rd(AW'(12'h010), v); check("R9 ram read between ticks", v, 8'hA5);
            pulse_tick();
        end
        @(negedge clk); pwr_good = 1'b0;
        wr(AW'(12'h010), 8'h3C);
        wr(TB + 2, 8'h55);
        rd(AW'(12'h010), v); check("R10 read while down", v, 8'h00);
        pulse_tick();
        pulse_tick();
        @(negedge clk); pwr_good = 1'b1;
        wait_cyc(2);
        rd(AW'(12'h010), v); check("R11 read during recovery", v, 8'h00);
        wr(AW'(12'h010), 8'h77);
        wait_cyc(REC + 2);
        rd(AW'(12'h010), v); check("R10 R11 ram kept", v, 8'hA5);
        chk_time("R9 R10 no lost ticks", 8'h20, 8'h24, 8'h03, 8'h15, 8'h05, 8'h10, 8'h20, 8'h10);
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(REC + 4);
        t_reset();
        t_ram();
        t_rollover();
        t_leap();
        t_write_load();
        t_power();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule